// File: doc/BRIEF.md
# Lock-Line Reservation Unit

This block keeps a single load-linked reservation on one 128-byte line for atomic lock-line commands. A requester takes a reservation with a get-with-reservation command. The block records who made the request and which line it covers, starts a 128-byte read of that line, and reports a status code. A later conditional store from the same requester to the same line succeeds. It starts a 128-byte write and reports success. Any other conditional store fails. Unconditional stores always write, and only the non-quiet form reports a status.

The block also watches every ordinary put that the system performs, whatever its source. When a put's byte range touches the reserved line, the reservation is dropped without any report. Outcomes go into a one-entry status slot. A newer outcome replaces an unread one, and a read waits until an entry is present. The block only requests data movement: each line transfer appears for one cycle on a transfer request port.

Top module: `lockline_resv`

## Requirements
- R1: A get-with-reservation command (op code 0) sets the reservation valid, records the requester and the line index (address bits above bit 6), and requests a 128-byte get (xfer_is_put = 0) at the line-aligned address. It posts status code 1.
- R2: A conditional store (op code 1) succeeds when a reservation is valid, the requester equals the recorded owner and the command's line index equals the reserved line index. On success it requests a 128-byte put at the line-aligned address and posts status code 2.
- R3: A conditional store that does not succeed posts status code 3 and requests no transfer.
- R4: A conditional store from the owner clears the reservation whether it succeeds or fails. A conditional store from any other requester leaves the reservation unchanged.
- R5: An unconditional store (op code 2) requests a 128-byte put and posts status code 4. The quiet unconditional store (op code 3) requests the same put but posts nothing, and leaves the status slot unchanged.
- R6: An unconditional or quiet unconditional store to the reserved line clears the reservation. A store to any other line leaves it valid.
- R7: A snooped put covering bytes put_addr to put_addr+put_len-1 clears the reservation when that range shares any byte with the reserved line. The range does not wrap past the top of the address space, and a length of 0 has no effect. When a get-with-reservation arrives in the same cycle, the new reservation is kept.
- R8: The status slot holds one entry. A new status replaces an unread one, and stat_count shows 1 while an entry is held.
- R9: stat_rd_ack is high only while stat_rd is high and an entry is held, so a read of an empty slot stalls. An acknowledged read empties the slot, unless a new status is written in the same cycle, in which case the new status is held.
- R10: After reset no reservation is valid, the status slot is empty and no transfer is requested.
- R11: Transfer requests, status updates and reservation changes appear at the clock edge that samples the command or snooped put. A transfer request lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Atomic command present this cycle |
| cmd_op | input | 2 | 0 get-with-reservation, 1 conditional, 2 unconditional, 3 quiet unconditional |
| cmd_owner | input | OWNER_W | Requester identity |
| cmd_addr | input | ADDR_W | Command effective address |
| put_valid | input | 1 | Snooped ordinary put present this cycle |
| put_addr | input | ADDR_W | First byte of the snooped put |
| put_len | input | LEN_W | Byte count of the snooped put |
| xfer_valid | output | 1 | 128-byte transfer request, one cycle |
| xfer_is_put | output | 1 | 1 for a put, 0 for a get |
| xfer_addr | output | ADDR_W | Line-aligned transfer address |
| stat_rd | input | 1 | Status read request |
| stat_rd_ack | output | 1 | Read completes this cycle |
| stat_data | output | 3 | Held status code |
| stat_count | output | 1 | Number of held entries (0 or 1) |
| resv_valid | output | 1 | Reservation currently held |

## Verification
The bench uses the default parameters: a 32-bit address, 4-bit requester identity and 16-bit put length. The wide length lets a single snooped put cover many lines, from below the reserved line to above it. The 32-bit address lets a put run past the top of the address space, which shows that the range does not wrap. Byte-exact edges are exercised as well: puts that end one byte before the line, start one byte after it, or touch only its first or last byte. A scoreboard compares the status codes as they are read, including a value replaced before any read, a read in the same cycle as a write, and a stalled read of an empty slot.

// File: rtl/lockline_resv.sv
module lockline_resv #(
  parameter int ADDR_W  = 32,
  parameter int OWNER_W = 4,
  parameter int LEN_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [OWNER_W-1:0] cmd_owner,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic               put_valid,
  input  logic [ADDR_W-1:0]  put_addr,
  input  logic [LEN_W-1:0]   put_len,
  output logic               xfer_valid,
  output logic               xfer_is_put,
  output logic [ADDR_W-1:0]  xfer_addr,
  input  logic               stat_rd,
  output logic               stat_rd_ack,
  output logic [2:0]         stat_data,
  output logic               stat_count,
  output logic               resv_valid
);
  localparam int LINE_W = 7;
  localparam int IDX_W  = ADDR_W - LINE_W;
  localparam logic [1:0] OP_GETR = 2'd0;
  localparam logic [1:0] OP_COND = 2'd1;
  localparam logic [1:0] OP_UNC  = 2'd2;
  localparam logic [1:0] OP_UNCQ = 2'd3;
  localparam logic [2:0] ST_GET   = 3'd1;
  localparam logic [2:0] ST_COK   = 3'd2;
  localparam logic [2:0] ST_CFAIL = 3'd3;
  localparam logic [2:0] ST_UNC   = 3'd4;

  logic [OWNER_W-1:0] resv_owner;
  logic [IDX_W-1:0]   resv_line;
  logic               slot_full;
  logic [2:0]         slot_code;

  logic [IDX_W-1:0] cmd_line;
  logic is_get, is_cond, is_unc, is_uncq;
  logic owner_hit, line_hit, cond_ok;
  assign cmd_line  = cmd_addr[ADDR_W-1:LINE_W];
  assign is_get    = cmd_valid && cmd_op == OP_GETR;
  assign is_cond   = cmd_valid && cmd_op == OP_COND;
  assign is_unc    = cmd_valid && cmd_op == OP_UNC;
  assign is_uncq   = cmd_valid && cmd_op == OP_UNCQ;
  assign owner_hit = resv_valid && resv_owner == cmd_owner;
  assign line_hit  = resv_valid && resv_line == cmd_line;
  assign cond_ok   = is_cond && owner_hit && line_hit;

  logic [ADDR_W:0] put_end;
  logic [IDX_W:0]  put_first, put_last;
  logic            snoop_hit, store_hit, resv_kill;
  assign put_end   = {1'b0, put_addr} + {{(ADDR_W+1-LEN_W){1'b0}}, put_len} - 1'b1;
  assign put_first = {1'b0, put_addr[ADDR_W-1:LINE_W]};
  assign put_last  = put_end[ADDR_W:LINE_W];
  assign snoop_hit = put_valid && put_len != '0 && resv_valid &&
                     put_first <= {1'b0, resv_line} && {1'b0, resv_line} <= put_last;
  assign store_hit = (is_unc || is_uncq) && line_hit;
  assign resv_kill = snoop_hit || store_hit || (is_cond && owner_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      resv_owner <= '0;
      resv_line  <= '0;
    end else if (is_get) begin
      resv_valid <= 1'b1;
      resv_owner <= cmd_owner;
      resv_line  <= cmd_line;
    end else if (resv_kill) begin
      resv_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_valid  <= 1'b0;
      xfer_is_put <= 1'b0;
      xfer_addr   <= '0;
    end else begin
      xfer_valid  <= is_get || cond_ok || is_unc || is_uncq;
      xfer_is_put <= !is_get;
      xfer_addr   <= {cmd_line, {LINE_W{1'b0}}};
    end
  end

  logic       st_wr;
  logic [2:0] st_code;
  assign st_wr   = is_get || is_cond || is_unc;
  assign st_code = is_get ? ST_GET : is_unc ? ST_UNC : cond_ok ? ST_COK : ST_CFAIL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_full <= 1'b0;
      slot_code <= '0;
    end else if (st_wr) begin
      slot_full <= 1'b1;
      slot_code <= st_code;
    end else if (stat_rd_ack) begin
      slot_full <= 1'b0;
    end
  end

  assign stat_rd_ack = stat_rd && slot_full;
  assign stat_data   = slot_code;
  assign stat_count  = slot_full;
endmodule

// File: rtl/lockline_resv_chk.sv
module lockline_resv_chk #(
  parameter int ADDR_W  = 32,
  parameter int OWNER_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [1:0]         cmd_op,
  input logic [OWNER_W-1:0] cmd_owner,
  input logic               xfer_valid,
  input logic               xfer_is_put,
  input logic [ADDR_W-1:0]  xfer_addr,
  input logic               stat_rd_ack,
  input logic [2:0]         stat_data,
  input logic               stat_count,
  input logic               resv_valid
);
  a_r1_get_reserves: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd0 |=> resv_valid && xfer_valid && !xfer_is_put && stat_count && stat_data == 3'd1);

  a_r1_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> xfer_addr[6:0] == 7'd0);

  a_r3_fail_without_resv: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd1 && !resv_valid |=> !xfer_valid && stat_data == 3'd3 && stat_count);

  a_r5_quiet_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd3 && !stat_count |=> !stat_count && xfer_valid && xfer_is_put);

  a_r9_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_ack && !(cmd_valid && cmd_op != 2'd3) |=> !stat_count);

  a_r11_xfer_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> $past(cmd_valid));

  logic unused_owner;
  assign unused_owner = ^cmd_owner;
endmodule

bind lockline_resv lockline_resv_chk #(.ADDR_W(ADDR_W), .OWNER_W(OWNER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_owner(cmd_owner),
  .xfer_valid(xfer_valid), .xfer_is_put(xfer_is_put), .xfer_addr(xfer_addr),
  .stat_rd_ack(stat_rd_ack), .stat_data(stat_data), .stat_count(stat_count),
  .resv_valid(resv_valid)
);

// File: tb/lockline_resv_tb.sv
module lockline_resv_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [3:0]  cmd_owner = '0;
  logic [31:0] cmd_addr = '0;
  logic        put_valid = 1'b0;
  logic [31:0] put_addr = '0;
  logic [15:0] put_len = '0;
  logic        stat_rd = 1'b0;
  logic        xfer_valid, xfer_is_put, stat_rd_ack, stat_count, resv_valid;
  logic [31:0] xfer_addr;
  logic [2:0]  stat_data;

  lockline_resv u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_owner(cmd_owner),
    .cmd_addr(cmd_addr), .put_valid(put_valid), .put_addr(put_addr), .put_len(put_len),
    .xfer_valid(xfer_valid), .xfer_is_put(xfer_is_put), .xfer_addr(xfer_addr),
    .stat_rd(stat_rd), .stat_rd_ack(stat_rd_ack), .stat_data(stat_data),
    .stat_count(stat_count), .resv_valid(resv_valid)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && stat_rd && stat_rd_ack) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected read ack", stat_data, 0);
      end else begin
        automatic logic [2:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(stat_data == e, t, stat_data, e);
      end
    end
  end

  task automatic expect_stat(input logic [2:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [3:0] own, input logic [31:0] a);
    @(posedge clk) #1;
    cmd_valid = 1'b1; cmd_op = op; cmd_owner = own; cmd_addr = a;
    @(posedge clk) #1;
    cmd_valid = 1'b0;
  endtask

  task automatic do_put(input logic [31:0] a, input logic [15:0] len);
    @(posedge clk) #1;
    put_valid = 1'b1; put_addr = a; put_len = len;
    @(posedge clk) #1;
    put_valid = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] e, input string t);
    expect_stat(e, t);
    @(posedge clk) #1;
    stat_rd = 1'b1;
    @(negedge clk);
    while (!stat_rd_ack) @(negedge clk);
    @(posedge clk) #1;
    stat_rd = 1'b0;
  endtask

  task automatic chk_xfer(input bit v, input bit p, input logic [31:0] a, input string t);
    chk(xfer_valid == v, t, xfer_valid, v);
    if (v) begin
      chk(xfer_is_put == p, t, xfer_is_put, p);
      chk(xfer_addr == a, t, xfer_addr, a);
    end
  endtask

  task automatic finish_up;
    if (exp_q.size() != 0) chk(1'b0, "R8 statuses left unread", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 1, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!resv_valid, "R10 reset reservation", resv_valid, 0);
    chk(!stat_count, "R10 reset slot", stat_count, 0);
    chk(!xfer_valid, "R10 reset transfer", xfer_valid, 0);

    // R1 get with reservation, then R2 success at another offset in the same line
    do_cmd(2'd0, 4'd3, 32'h1000_0040);
    chk_xfer(1, 0, 32'h1000_0000, "R1 get request");
    chk(resv_valid, "R1 reservation set", resv_valid, 1);
    @(posedge clk) #1;
    chk_xfer(0, 0, 0, "R11 single-cycle request");
    do_read(3'd1, "R1 get status");
    do_cmd(2'd1, 4'd3, 32'h1000_0000);
    chk_xfer(1, 1, 32'h1000_0000, "R2 conditional put");
    chk(!resv_valid, "R4 owner success clears", resv_valid, 1);
    do_read(3'd2, "R2 success status");

    // R3 with no reservation
    do_cmd(2'd1, 4'd3, 32'h1000_0000);
    chk_xfer(0, 0, 0, "R3 no transfer on fail");
    do_read(3'd3, "R3 failure status");

    // R4 non-owner leaves, owner wrong line clears
    do_cmd(2'd0, 4'd2, 32'h0000_3000);
    do_read(3'd1, "R1 second get");
    do_cmd(2'd1, 4'd5, 32'h0000_3000);
    chk(resv_valid, "R4 non-owner keeps", resv_valid, 0);
    do_read(3'd3, "R3 non-owner fails");
    do_cmd(2'd1, 4'd2, 32'h0000_3080);
    chk_xfer(0, 0, 0, "R3 wrong line no transfer");
    chk(!resv_valid, "R4 owner failure clears", resv_valid, 1);
    do_read(3'd3, "R3 wrong line fails");

    // R8 overwrite before read
    do_cmd(2'd0, 4'd1, 32'h0000_4000);
    do_cmd(2'd1, 4'd1, 32'h0000_4010);
    chk(stat_count, "R8 one entry held", stat_count, 0);
    do_read(3'd2, "R8 newest status kept");
    @(negedge clk);
    chk(!stat_count, "R9 read empties", stat_count, 1);

    // R5 and R6 unconditional stores
    do_cmd(2'd0, 4'd7, 32'h0000_6000);
    do_read(3'd1, "R1 get for R6");
    do_cmd(2'd2, 4'd9, 32'h0000_6100);
    chk_xfer(1, 1, 32'h0000_6100, "R5 unconditional put");
    chk(resv_valid, "R6 other line keeps", resv_valid, 0);
    do_read(3'd4, "R5 unconditional status");
    do_cmd(2'd3, 4'd9, 32'h0000_6180);
    chk_xfer(1, 1, 32'h0000_6180, "R5 quiet put");
    @(negedge clk);
    chk(!stat_count, "R5 quiet posts nothing", stat_count, 1);
    chk(resv_valid, "R6 quiet other line keeps", resv_valid, 0);
    do_cmd(2'd3, 4'd9, 32'h0000_6070);
    chk(!resv_valid, "R6 quiet same line clears", resv_valid, 1);
    do_cmd(2'd0, 4'd7, 32'h0000_6000);
    do_cmd(2'd3, 4'd7, 32'h0000_7000);
    chk(stat_count && stat_data == 3'd1, "R5 quiet keeps unread entry", stat_data, 1);
    do_cmd(2'd2, 4'd7, 32'h0000_6004);
    chk(!resv_valid, "R6 unconditional same line clears", resv_valid, 1);
    do_read(3'd4, "R5 status replaced");

    // R7 snooped puts against line 0x2000..0x207F
    do_cmd(2'd0, 4'd4, 32'h0000_2000);
    do_read(3'd1, "R1 get for R7");
    do_put(32'h0000_1F80, 16'h0080);
    chk(resv_valid, "R7 ends just below", resv_valid, 0);
    do_put(32'h0000_2080, 16'h0010);
    chk(resv_valid, "R7 starts just above", resv_valid, 0);
    do_put(32'h0000_2000, 16'h0000);
    chk(resv_valid, "R7 zero length ignored", resv_valid, 0);
    do_put(32'h0000_1FFF, 16'h0002);
    chk(!resv_valid, "R7 first byte touched", resv_valid, 1);
    do_cmd(2'd0, 4'd4, 32'h0000_2000);
    do_put(32'h0000_207F, 16'h0001);
    chk(!resv_valid, "R7 last byte touched", resv_valid, 1);
    do_cmd(2'd0, 4'd4, 32'h0000_2000);
    do_put(32'h0000_1000, 16'h4000);
    chk(!resv_valid, "R7 wide span covers", resv_valid, 1);
    do_cmd(2'd0, 4'd4, 32'h0000_0000);
    do_put(32'hFFFF_FFF0, 16'h0020);
    chk(resv_valid, "R7 no wrap to line 0", resv_valid, 0);
    do_cmd(2'd0, 4'd4, 32'hFFFF_FF80);
    do_put(32'hFFFF_FFF0, 16'h0020);
    chk(!resv_valid, "R7 top line overlapped", resv_valid, 1);
    // get and overlapping put in the same cycle
    @(posedge clk) #1;
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_owner = 4'd8; cmd_addr = 32'h0000_8000;
    put_valid = 1'b1; put_addr = 32'h0000_8000; put_len = 16'h0080;
    @(posedge clk) #1;
    cmd_valid = 1'b0; put_valid = 1'b0;
    chk(resv_valid, "R7 same-cycle get wins", resv_valid, 0);
    do_cmd(2'd1, 4'd8, 32'h0000_8000);
    chk_xfer(1, 1, 32'h0000_8000, "R2 after same-cycle get");
    do_read(3'd2, "R2 status after R7 priority");

    // R9 stall on empty slot, then completion when a status arrives
    @(posedge clk) #1;
    stat_rd = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!stat_rd_ack, "R9 empty read stalls", stat_rd_ack, 0);
    end
    expect_stat(3'd4, "R9 stalled read completes");
    do_cmd(2'd2, 4'd1, 32'h0000_9000);
    @(negedge clk);
    @(posedge clk) #1;
    stat_rd = 1'b0;
    @(negedge clk);
    chk(!stat_count, "R9 slot empty after stalled read", stat_count, 1);

    // R9 read and write in the same cycle
    do_cmd(2'd0, 4'd6, 32'h0000_5000);
    expect_stat(3'd1, "R9 old value read");
    expect_stat(3'd2, "R9 same-cycle write held");
    @(posedge clk) #1;
    stat_rd = 1'b1;
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_owner = 4'd6; cmd_addr = 32'h0000_5000;
    @(posedge clk) #1;
    cmd_valid = 1'b0;
    chk(stat_count, "R9 new entry survives read", stat_count, 0);
    @(negedge clk);
    @(posedge clk) #1;
    stat_rd = 1'b0;
    @(negedge clk);
    chk(!stat_count, "R9 final read empties", stat_count, 1);

    repeat (2) @(posedge clk);
    finish_up();
  end
endmodule